// File: doc/BRIEF.md
# DDR2 Auto-Precharge Bank Timing Tracker

This block sits beside the command scheduler of a DDR2 memory controller and watches each command as it is issued: an opcode, a bank number, the A10 auto-precharge bit and a valid strobe. For every bank it keeps a small state machine and a few saturating cycle counters. These model the moment at which the internal precharge that follows a READ with auto-precharge really begins. That moment is the nominal point AL + BL/2 cycles after the read, moved later while tRAS(min) since the ACTIVATE is not yet met, or while tRTP(min) is not yet met. tRTP is counted from two cycles before the end of the burst's prefetch. The tRP countdown starts from wherever the precharge actually begins.

The scheduler reads a per-bank ACTIVATE-ready vector. It also reads two gates that say whether a READ or a WRITE may be issued yet, given the most recent READ with auto-precharge to any bank. A command that breaks the tracked timing produces a one-cycle violation pulse together with its bank number, and it has no effect on any bank. Every timing value is a run-time input, an integer count of clock cycles that the user has already rounded up from nanoseconds. The inputs are the additive latency, the burst length select, tRAS, tRTP and tRP.

Top module: `ddr2_ap_tracker`

## Requirements
- R1: After reset every bank is idle, act_ready is all ones, rd_ok and wr_ok are 1, and viol is 0.
- R2: Command opcodes are 0 NOP, 1 ACTIVATE, 2 READ, 3 WRITE and 4 PRECHARGE. Bit i of act_ready belongs to bank i. A READ accepted at edge r with cmd_ap=1 starts the bank's internal precharge no earlier than edge r + AL + BL/2, where BL/2 is 2 when cfg_bl8=0 and 4 when cfg_bl8=1.
- R3: If tRAS has not elapsed since the bank's ACTIVATE at edge a, the internal precharge start is pushed out to edge a + tRAS.
- R4: The internal precharge start is also pushed out to edge r + AL + BL/2 - 2 + tRTP when that edge is later.
- R5: act_ready for the bank becomes 1 so that an ACTIVATE is legal exactly tRP cycles after the actual precharge start. With no push-out the spacing is AL + BL/2 + tRP.
- R6: A READ with cmd_ap=0 leaves the bank open. act_ready stays 0 for that bank indefinitely, and no violation is raised.
- R7: An explicit PRECHARGE to an open bank is legal once tRAS has elapsed, and act_ready follows it by tRP cycles. Before tRAS it is a violation.
- R8: After a READ with auto-precharge accepted at edge r, a READ to any bank is legal from edge r + BL/2 and a WRITE from edge r + BL/2 + 2, and rd_ok and wr_ok show this. An ACTIVATE or PRECHARGE to another bank is legal from edge r + 1.
- R9: An illegal command raises viol for exactly the cycle after it, with viol_bank equal to its bank, and changes no bank state. Illegal commands are an ACTIVATE to a bank that is not ready, a READ or WRITE to a bank that is not open or ahead of rd_ok/wr_ok, and a PRECHARGE to a bank that is auto-precharging or still in tRP.
- R10: Banks auto-precharge concurrently, each with its own tRAS push-out and its own ready time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A command is issued this cycle |
| cmd_op | input | 3 | Command opcode (R2 encoding) |
| cmd_bank | input | BW | Target bank |
| cmd_ap | input | 1 | Auto-precharge bit (A10) of a READ |
| cfg_al | input | ALW | Additive latency in cycles |
| cfg_bl8 | input | 1 | 1 selects burst length 8, 0 selects 4 |
| cfg_tras | input | CW | tRAS(min) in cycles |
| cfg_trtp | input | CW | tRTP(min) in cycles |
| cfg_trp | input | CW | tRP in cycles |
| act_ready | output | NB | Per-bank: ACTIVATE legal at the next edge |
| rd_ok | output | 1 | READ legal at the next edge |
| wr_ok | output | 1 | WRITE legal at the next edge |
| viol | output | 1 | Previous-cycle command was illegal |
| viol_bank | output | BW | Bank of the illegal command |

## Verification
The ACTIVATE-ready edge after a READ with auto-precharge is measured across both burst lengths and additive latencies 0 to 4 with short tRTP. This confirms the nominal start point and the tRP count. Long-tRTP cases and an ACTIVATE followed at once by the read separate the tRTP push-out from the tRAS push-out, because each one alone moves the ready edge to a different cycle. Two banks closing together with different ACTIVATE ages show that each bank keeps its own timing. Deliberately early READs, WRITEs, ACTIVATEs and PRECHARGEs show that violations are flagged with the right bank and leave the bank's later ready time unchanged.

// File: rtl/ddr2_ap_pkg.sv
package ddr2_ap_pkg;

    typedef enum logic [2:0] {
        OP_NOP = 3'd0,
        OP_ACT = 3'd1,
        OP_RD  = 3'd2,
        OP_WR  = 3'd3,
        OP_PRE = 3'd4
    } cmd_op_e;

    typedef enum logic [1:0] {
        BK_IDLE   = 2'd0,
        BK_OPEN   = 2'd1,
        BK_APWAIT = 2'd2,
        BK_PRECH  = 2'd3
    } bank_st_e;

endpackage

// File: rtl/ddr2_ap_bank.sv
module ddr2_ap_bank
    import ddr2_ap_pkg::*;
#(
    parameter int CW  = 6,
    parameter int ALW = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [ALW-1:0] cfg_al,
    input  logic           cfg_bl8,
    input  logic [CW-1:0]  cfg_tras,
    input  logic [CW-1:0]  cfg_trtp,
    input  logic [CW-1:0]  cfg_trp,
    input  logic           do_act,
    input  logic           do_rdap,
    input  logic           do_pre,
    output logic           is_open,
    output logic           ras_met,
    output logic           act_rdy
);
    localparam int LW  = CW + 2;
    localparam int AGW = LW + 2;

    typedef struct packed {
        bank_st_e      st;
        logic [LW-1:0] ras;
        logic [LW-1:0] pend;
        logic [LW-1:0] rtp;
        logic [LW-1:0] rp;
    } bank_regs_t;

    bank_regs_t q, d;

    logic [LW-1:0] half_w;
    logic [LW-1:0] nom_w;
    logic [LW-1:0] rtpx_w;
    logic          start_ok;

    function automatic logic [LW-1:0] dec1(input logic [LW-1:0] v);
        return (v == '0) ? '0 : v - LW'(1);
    endfunction

    assign half_w   = cfg_bl8 ? LW'(4) : LW'(2);
    assign nom_w    = LW'(cfg_al) + half_w;
    assign rtpx_w   = LW'(cfg_al) + half_w - LW'(2) + LW'(cfg_trtp);
    assign start_ok = (q.pend == '0) && (q.rtp == '0) && (q.ras == '0);

    always_comb begin
        d      = q;
        d.ras  = dec1(q.ras);
        d.pend = dec1(q.pend);
        d.rtp  = dec1(q.rtp);
        d.rp   = dec1(q.rp);
        if (do_act) begin
            d.st  = BK_OPEN;
            d.ras = dec1(LW'(cfg_tras));
        end else begin
            case (q.st)
                BK_OPEN: begin
                    if (do_rdap) begin
                        d.st   = BK_APWAIT;
                        d.pend = dec1(nom_w);
                        d.rtp  = dec1(rtpx_w);
                    end else if (do_pre) begin
                        d.st = BK_PRECH;
                        d.rp = dec1(LW'(cfg_trp));
                    end
                end
                BK_APWAIT: begin
                    if (start_ok) begin
                        d.st = BK_PRECH;
                        d.rp = dec1(LW'(cfg_trp));
                    end
                end
                BK_PRECH: begin
                    if (q.rp == '0) begin
                        d.st = BK_IDLE;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{st: BK_IDLE, ras: '0, pend: '0, rtp: '0, rp: '0};
        end else begin
            q <= d;
        end
    end

    assign is_open = (q.st == BK_OPEN);
    assign ras_met = (q.ras == '0);
    assign act_rdy = (q.st == BK_IDLE) || ((q.st == BK_PRECH) && (q.rp == '0));

    // Independent age counters used only by the checks below.
    logic [AGW-1:0] age_rd_q, age_act_q;
    logic           ap_start;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            age_rd_q  <= '0;
            age_act_q <= '0;
        end else begin
            if (do_rdap)            age_rd_q <= AGW'(1);
            else if (~&age_rd_q)    age_rd_q <= age_rd_q + AGW'(1);
            if (do_act)             age_act_q <= AGW'(1);
            else if (~&age_act_q)   age_act_q <= age_act_q + AGW'(1);
        end
    end

    assign ap_start = (q.st == BK_APWAIT) && (d.st == BK_PRECH);

    a_r2_not_before_nominal: assert property (@(posedge clk) disable iff (!rst_n)
        ap_start |-> (age_rd_q >= AGW'(nom_w)));

    a_r4_not_before_rtp: assert property (@(posedge clk) disable iff (!rst_n)
        ap_start |-> (age_rd_q >= AGW'(rtpx_w)));

    a_r3_not_before_ras: assert property (@(posedge clk) disable iff (!rst_n)
        ap_start |-> (age_act_q >= AGW'(cfg_tras)));

    a_r9_act_only_when_ready: assert property (@(posedge clk) disable iff (!rst_n)
        do_act |-> act_rdy);

    a_r9_rdap_only_when_open: assert property (@(posedge clk) disable iff (!rst_n)
        do_rdap |=> (q.st == BK_APWAIT));

endmodule

// File: rtl/ddr2_ap_xgap.sv
module ddr2_ap_xgap #(
    parameter int MAX_GAP = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cfg_bl8,
    input  logic rdap_any,
    output logic rd_ok,
    output logic wr_ok
);
    localparam int XW = $clog2(MAX_GAP + 1);

    typedef struct packed {
        logic [XW-1:0] rd;
        logic [XW-1:0] wr;
    } gap_regs_t;

    gap_regs_t     q, d;
    logic [XW-1:0] half_w;

    assign half_w = cfg_bl8 ? XW'(4) : XW'(2);

    always_comb begin
        d    = q;
        d.rd = (q.rd == '0) ? '0 : q.rd - XW'(1);
        d.wr = (q.wr == '0) ? '0 : q.wr - XW'(1);
        if (rdap_any) begin
            d.rd = half_w - XW'(1);
            d.wr = half_w + XW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{rd: '0, wr: '0};
        end else begin
            q <= d;
        end
    end

    assign rd_ok = (q.rd == '0);
    assign wr_ok = (q.wr == '0);

    a_r8_rd_gate_after_rdap: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_ok) |-> $past(rdap_any));

    a_r8_wr_window_covers_rd: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_ok |-> !wr_ok);

endmodule

// File: rtl/ddr2_ap_gate.sv
module ddr2_ap_gate
    import ddr2_ap_pkg::*;
#(
    parameter int NB = 8,
    parameter int BW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic [2:0]    cmd_op,
    input  logic [BW-1:0] cmd_bank,
    input  logic          cmd_ap,
    input  logic [NB-1:0] is_open,
    input  logic [NB-1:0] ras_met,
    input  logic [NB-1:0] act_rdy,
    input  logic          rd_ok,
    input  logic          wr_ok,
    output logic [NB-1:0] do_act,
    output logic [NB-1:0] do_rdap,
    output logic [NB-1:0] do_pre,
    output logic          rdap_any,
    output logic          bad
);
    logic legal;
    logic acc;

    always_comb begin
        case (cmd_op)
            OP_ACT:  legal = act_rdy[cmd_bank];
            OP_RD:   legal = is_open[cmd_bank] && rd_ok;
            OP_WR:   legal = is_open[cmd_bank] && wr_ok;
            OP_PRE:  legal = (is_open[cmd_bank] && ras_met[cmd_bank]) || act_rdy[cmd_bank];
            default: legal = 1'b1;
        endcase
    end

    assign acc = cmd_valid && legal;
    assign bad = cmd_valid && !legal;

    for (genvar g = 0; g < NB; g++) begin : g_sel
        logic hit;
        assign hit        = acc && (cmd_bank == BW'(g));
        assign do_act[g]  = hit && (cmd_op == OP_ACT);
        assign do_rdap[g] = hit && (cmd_op == OP_RD) && cmd_ap;
        assign do_pre[g]  = hit && (cmd_op == OP_PRE) && is_open[g];
    end

    assign rdap_any = |do_rdap;

    a_r6_plain_read_no_ap: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && (cmd_op == OP_RD) && !cmd_ap) |-> !rdap_any);

endmodule

// File: rtl/ddr2_ap_tracker.sv
module ddr2_ap_tracker
    import ddr2_ap_pkg::*;
#(
    parameter int NB  = 8,
    parameter int CW  = 6,
    parameter int ALW = 3,
    parameter int BW  = $clog2(NB)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cmd_valid,
    input  logic [2:0]     cmd_op,
    input  logic [BW-1:0]  cmd_bank,
    input  logic           cmd_ap,
    input  logic [ALW-1:0] cfg_al,
    input  logic           cfg_bl8,
    input  logic [CW-1:0]  cfg_tras,
    input  logic [CW-1:0]  cfg_trtp,
    input  logic [CW-1:0]  cfg_trp,
    output logic [NB-1:0]  act_ready,
    output logic           rd_ok,
    output logic           wr_ok,
    output logic           viol,
    output logic [BW-1:0]  viol_bank
);
    typedef struct packed {
        logic          flag;
        logic [BW-1:0] bank;
    } viol_regs_t;

    viol_regs_t    q, d;
    logic [NB-1:0] open_v, ras_v, rdy_v;
    logic [NB-1:0] do_act, do_rdap, do_pre;
    logic          rdap_any, bad;

    ddr2_ap_gate #(.NB(NB), .BW(BW)) u_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .cmd_valid(cmd_valid),
        .cmd_op   (cmd_op),
        .cmd_bank (cmd_bank),
        .cmd_ap   (cmd_ap),
        .is_open  (open_v),
        .ras_met  (ras_v),
        .act_rdy  (rdy_v),
        .rd_ok    (rd_ok),
        .wr_ok    (wr_ok),
        .do_act   (do_act),
        .do_rdap  (do_rdap),
        .do_pre   (do_pre),
        .rdap_any (rdap_any),
        .bad      (bad)
    );

    ddr2_ap_xgap #(.MAX_GAP(6)) u_xgap (
        .clk     (clk),
        .rst_n   (rst_n),
        .cfg_bl8 (cfg_bl8),
        .rdap_any(rdap_any),
        .rd_ok   (rd_ok),
        .wr_ok   (wr_ok)
    );

    for (genvar g = 0; g < NB; g++) begin : g_bank
        ddr2_ap_bank #(.CW(CW), .ALW(ALW)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .cfg_al  (cfg_al),
            .cfg_bl8 (cfg_bl8),
            .cfg_tras(cfg_tras),
            .cfg_trtp(cfg_trtp),
            .cfg_trp (cfg_trp),
            .do_act  (do_act[g]),
            .do_rdap (do_rdap[g]),
            .do_pre  (do_pre[g]),
            .is_open (open_v[g]),
            .ras_met (ras_v[g]),
            .act_rdy (rdy_v[g])
        );
    end

    always_comb begin
        d      = q;
        d.flag = bad;
        if (bad) begin
            d.bank = cmd_bank;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '{flag: 1'b0, bank: '0};
        end else begin
            q <= d;
        end
    end

    assign act_ready = rdy_v;
    assign viol      = q.flag;
    assign viol_bank = q.bank;

    a_r9_viol_follows_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        viol |-> $past(cmd_valid));

endmodule

// File: tb/ddr2_ap_tracker_test.sv
`timescale 1ns/1ps
module ddr2_ap_tracker_test;
    import ddr2_ap_pkg::*;

    localparam int NB = 8, CW = 6, ALW = 3, BW = 3;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           cmd_valid = 1'b0;
    logic [2:0]     cmd_op = 3'd0;
    logic [BW-1:0]  cmd_bank = '0;
    logic           cmd_ap = 1'b0;
    logic [ALW-1:0] cfg_al = '0;
    logic           cfg_bl8 = 1'b0;
    logic [CW-1:0]  cfg_tras = CW'(3);
    logic [CW-1:0]  cfg_trtp = CW'(2);
    logic [CW-1:0]  cfg_trp = CW'(3);
    logic [NB-1:0]  act_ready;
    logic           rd_ok, wr_ok, viol;
    logic [BW-1:0]  viol_bank;

    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    ddr2_ap_tracker #(.NB(NB), .CW(CW), .ALW(ALW)) uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_bank(cmd_bank), .cmd_ap(cmd_ap), .cfg_al(cfg_al), .cfg_bl8(cfg_bl8),
        .cfg_tras(cfg_tras), .cfg_trtp(cfg_trtp), .cfg_trp(cfg_trp),
        .act_ready(act_ready), .rd_ok(rd_ok), .wr_ok(wr_ok),
        .viol(viol), .viol_bank(viol_bank)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    task automatic reset_dut();
        cmd_valid = 1'b0;
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    task automatic set_cfg(input int al, input int bl8, input int tras, input int trtp, input int trp);
        cfg_al = ALW'(al); cfg_bl8 = bl8[0];
        cfg_tras = CW'(tras); cfg_trtp = CW'(trtp); cfg_trp = CW'(trp);
    endtask

    // Drives one command for one edge; returns that edge and viol sampled after it.
    task automatic issue(input cmd_op_e op, input int bank, input bit ap,
                         output int edge_no, output int v, output int vb);
        @(negedge clk);
        cmd_valid = 1'b1; cmd_op = op; cmd_bank = BW'(bank); cmd_ap = ap;
        edge_no = cyc + 1;
        @(posedge clk);
        #1;
        v = int'(viol); vb = int'(viol_bank);
        cmd_valid = 1'b0; cmd_op = OP_NOP; cmd_ap = 1'b0;
    endtask

    function automatic bit flag(input int which);
        if (which == 0) return rd_ok;
        if (which == 1) return wr_ok;
        return act_ready[which - 2];
    endfunction

    // First edge at which the flag allows the command, or -1.
    task automatic wait_flag(input int which, input int limit, output int edge_no);
        edge_no = -1;
        for (int i = 0; i < limit; i++) begin
            @(negedge clk);
            if (flag(which)) begin
                edge_no = cyc + 1;
                break;
            end
        end
    endtask

    function automatic int exp_d(input int al, input int bl8, input int trtp, input int trp, input int ras_left);
        int half, s;
        half = bl8 ? 4 : 2;
        s = al + half;
        if (al + half - 2 + trtp > s) s = al + half - 2 + trtp;
        if (ras_left > s) s = ras_left;
        return s + trp;
    endfunction

    task automatic t_reset();
        reset_dut();
        @(negedge clk);
        chk("R1 act_ready", int'(act_ready), 255);
        chk("R1 rd_ok", int'(rd_ok), 1);
        chk("R1 wr_ok", int'(wr_ok), 1);
        chk("R1 viol", int'(viol), 0);
    endtask

    task automatic t_nominal();
        int a, r, e, v, vb;
        for (int bl8 = 0; bl8 < 2; bl8++) begin
            for (int al = 0; al <= 4; al++) begin
                reset_dut();
                set_cfg(al, bl8, 3, 2, 3);
                issue(OP_ACT, al, 1'b0, a, v, vb);
                repeat (4) @(posedge clk);
                issue(OP_RD, al, 1'b1, r, v, vb);
                wait_flag(2 + al, 100, e);
                chk($sformatf("R2 R5 nominal bl8=%0d al=%0d", bl8, al), e - r, exp_d(al, bl8, 2, 3, 0));
            end
        end
    endtask

    task automatic t_rtp();
        int a, r, e, v, vb;
        reset_dut();
        set_cfg(1, 0, 2, 5, 4);
        issue(OP_ACT, 2, 1'b0, a, v, vb);
        repeat (4) @(posedge clk);
        issue(OP_RD, 2, 1'b1, r, v, vb);
        wait_flag(4, 100, e);
        chk("R4 trtp push bl4", e - r, 10);
        reset_dut();
        set_cfg(0, 1, 2, 6, 4);
        issue(OP_ACT, 6, 1'b0, a, v, vb);
        repeat (4) @(posedge clk);
        issue(OP_RD, 6, 1'b1, r, v, vb);
        wait_flag(8, 100, e);
        chk("R4 trtp push bl8", e - r, 12);
    endtask

    task automatic t_ras();
        int a, r, e, v, vb;
        reset_dut();
        set_cfg(0, 0, 15, 2, 3);
        issue(OP_ACT, 1, 1'b0, a, v, vb);
        issue(OP_RD, 1, 1'b1, r, v, vb);
        chk("R3 early rdap accepted", v, 0);
        wait_flag(3, 100, e);
        chk("R3 tras push", e - r, exp_d(0, 0, 2, 3, 15 - (r - a)));
    endtask

    task automatic t_plain();
        int a, r, p, e, v, vb;
        reset_dut();
        set_cfg(0, 0, 6, 2, 3);
        issue(OP_ACT, 3, 1'b0, a, v, vb);
        issue(OP_RD, 3, 1'b0, r, v, vb);
        chk("R6 plain read no viol", v, 0);
        wait_flag(5, 30, e);
        chk("R6 bank stays open", e, -1);
        issue(OP_PRE, 3, 1'b0, p, v, vb);
        chk("R7 pre legal", v, 0);
        wait_flag(5, 20, e);
        chk("R7 pre to ready", e - p, 3);
        issue(OP_ACT, 4, 1'b0, a, v, vb);
        issue(OP_PRE, 4, 1'b0, p, v, vb);
        chk("R7 early pre viol", v, 1);
        chk("R9 early pre bank", vb, 4);
        wait_flag(6, 3, e);
        chk("R9 early pre ignored", e, -1);
        repeat (6) @(posedge clk);
        issue(OP_PRE, 4, 1'b0, p, v, vb);
        chk("R7 late pre legal", v, 0);
        wait_flag(6, 20, e);
        chk("R7 late pre to ready", e - p, 3);
    endtask

    task automatic t_cross();
        int a, r, x, e, v, vb;
        reset_dut();
        set_cfg(0, 0, 2, 2, 3);
        issue(OP_ACT, 1, 1'b0, a, v, vb);
        issue(OP_ACT, 2, 1'b0, a, v, vb);
        issue(OP_ACT, 5, 1'b0, a, v, vb);
        repeat (4) @(posedge clk);
        issue(OP_RD, 1, 1'b1, r, v, vb);
        chk("R8 rd_ok low after rdap", int'(rd_ok), 0);
        chk("R8 wr_ok low after rdap", int'(wr_ok), 0);
        issue(OP_RD, 2, 1'b1, x, v, vb);
        chk("R8 early read viol", v, 1);
        chk("R9 early read bank", vb, 2);
        chk("R8 rd_ok at r+2", int'(rd_ok), 1);
        chk("R8 wr_ok still low", int'(wr_ok), 0);
        issue(OP_ACT, 6, 1'b0, x, v, vb);
        chk("R8 act other bank legal", v, 0);
        wait_flag(1, 10, e);
        chk("R8 write gap bl4", e - r, 4);
        issue(OP_WR, 5, 1'b0, x, v, vb);
        chk("R8 write after gap legal", v, 0);
        wait_flag(4, 30, e);
        chk("R9 ignored rdap leaves bank open", e, -1);
        reset_dut();
        set_cfg(0, 1, 2, 2, 3);
        issue(OP_ACT, 0, 1'b0, a, v, vb);
        repeat (4) @(posedge clk);
        issue(OP_RD, 0, 1'b1, r, v, vb);
        wait_flag(0, 10, e);
        chk("R8 read gap bl8", e - r, 4);
        wait_flag(1, 10, e);
        chk("R8 write gap bl8", e - r, 6);
    endtask

    task automatic t_concurrent();
        int a0, a7, r0, r7, v, vb;
        int e0 = -1, e7 = -1;
        reset_dut();
        set_cfg(2, 0, 12, 2, 3);
        issue(OP_ACT, 0, 1'b0, a0, v, vb);
        repeat (12) @(posedge clk);
        issue(OP_ACT, 7, 1'b0, a7, v, vb);
        issue(OP_RD, 0, 1'b1, r0, v, vb);
        @(posedge clk);
        issue(OP_RD, 7, 1'b1, r7, v, vb);
        chk("R8 second rdap at gap legal", v, 0);
        for (int i = 0; i < 60; i++) begin
            @(negedge clk);
            if (e0 < 0 && act_ready[0]) e0 = cyc + 1;
            if (e7 < 0 && act_ready[7]) e7 = cyc + 1;
        end
        chk("R10 bank0 ready", e0 - r0, exp_d(2, 0, 2, 3, 0));
        chk("R10 bank7 ready with tras push", e7 - r7, exp_d(2, 0, 2, 3, 12 - (r7 - a7)));
    endtask

    task automatic t_busy();
        int a, r, x, e, v, vb;
        reset_dut();
        set_cfg(1, 0, 4, 2, 3);
        issue(OP_ACT, 5, 1'b0, a, v, vb);
        issue(OP_ACT, 5, 1'b0, x, v, vb);
        chk("R9 act to open bank viol", v, 1);
        chk("R9 act to open bank number", vb, 5);
        repeat (4) @(posedge clk);
        issue(OP_RD, 5, 1'b1, r, v, vb);
        issue(OP_ACT, 5, 1'b0, x, v, vb);
        chk("R9 act during ap viol", v, 1);
        issue(OP_PRE, 5, 1'b0, x, v, vb);
        chk("R9 pre during ap viol", v, 1);
        wait_flag(7, 40, e);
        chk("R9 ignored cmds keep ready time", e - r, exp_d(1, 0, 2, 3, 0));
        @(negedge clk);
        chk("R9 viol cleared", int'(viol), 0);
    endtask

    initial begin
        #(4 * 100000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog R1-to-end run actual=timeout expected=completion");
        summary();
    end

    initial begin
        t_reset();
        t_nominal();
        t_rtp();
        t_ras();
        t_plain();
        t_cross();
        t_concurrent();
        t_busy();
        summary();
    end

endmodule